// File: doc/BRIEF.md
# Arbitrated Shared Memory with Atomic Swap

This block gives several requesters access to one small word-addressed memory over a single shared bus. A round-robin arbiter hands the bus to one requester at a time. The owner may issue a plain read, a plain write, or an atomic swap. A swap returns the word stored at an address and writes the requester's value into that address as one uninterrupted operation.

The bus is the only path to the memory array. A swap keeps bus ownership through both its read phase and its write phase, so the arbiter alone decides the order in which contending swaps take effect. This makes the block a suitable base for spin locks. A lock word of 0 means free. A requester swaps in 1, and it owns the lock only if the value returned is 0.

Each requester holds its valid bit and its fields steady until it sees its own done pulse. The read data is valid on the same cycle as the done pulse. The requester drops valid on the next cycle, or presents a new request.

Top module: `swap_lock_bus`

## Requirements
- R1: After reset, `grant` and `done` are all zero and every memory word reads back as 0.
- R2: A read (op code 2'b00) returns the addressed word on `rdata` in the same cycle as the requester's `done` pulse.
- R3: A write (op code 2'b01) stores the requester's data at the address, and `rdata` is 0 during its `done` pulse.
- R4: A swap (op code 2'b10) returns the word as it was before the swap and leaves the requester's data in that word.
- R5: `grant` for a swap stays high for exactly two consecutive cycles. For a read or a write it is high for exactly one cycle.
- R6: At most one `grant` bit is high in any cycle, so no access can fall between the two phases of a swap.
- R7: Requests that wait together are served in round-robin order. The next owner is the first waiting requester at or above the pointer, counting upward with wrap-around. After each completed transfer the pointer moves to the owner's index plus one. The pointer is 0 after reset.
- R8: Every request produces exactly one `done` pulse, one-hot, to the requester that held `grant` in the cycle before.
- R9: When several requesters swap 1 into a lock word that holds 0, exactly one of them gets 0 back.
- R10: Op code 2'b11 behaves as a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | NUM_REQ | Request valid, one bit per requester |
| reqOp | input | 2*NUM_REQ | Op code per requester: 00 read, 01 write, 10 swap, 11 read |
| reqAddr | input | ADDR_W*NUM_REQ | Word address per requester |
| reqWdata | input | DATA_W*NUM_REQ | Write or swap data per requester |
| grant | output | NUM_REQ | One-hot bus ownership |
| done | output | NUM_REQ | One-cycle completion pulse, one-hot |
| rdata | output | DATA_W | Response data, valid with `done` |

## Verification
The bench presents random subsets of requesters with mixed ops and colliding addresses. This targets two faults: an arbiter that skips or repeats a requester would complete requests out of the predicted order, and a pointer that advances before completion would grant the wrong requester next. It counts the cycles `grant` stays high for each transfer, so a swap that releases the bus after its read phase shows up as a one-cycle grant. A directed lock contest checks that exactly one of the contending swaps sees a free lock. A non-atomic swap, or one that returns the new value instead of the old, would hand the lock to zero or to several requesters. Checks on write responses, the spare op code and the post-reset contents catch a response path that leaks stale data.

// File: rtl/swap_bus_pkg.sv
package swap_bus_pkg;

  typedef enum logic [1:0] {
    OP_READ     = 2'b00,
    OP_WRITE    = 2'b01,
    OP_SWAP     = 2'b10,
    OP_READ_ALT = 2'b11
  } busOp_e;

  localparam int OP_W = 2;

  // strobes sent from control to datapath
  typedef struct packed {
    logic latchReq;  // capture winner's address and data
    logic memWrite;  // write held data at held address
    logic capRead;   // load response register from memory
    logic clrRead;   // clear response register
  } dpStrobe_t;

endpackage

// File: rtl/swap_rr_arbiter.sv
module swap_rr_arbiter #(
  parameter int NUM_REQ = 4,
  localparam int IDX_W = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_REQ-1:0] reqVec,
  input  logic               advance,
  input  logic [IDX_W-1:0]   advIdx,
  output logic               winValid,
  output logic [IDX_W-1:0]   winIdx
);

  logic [IDX_W-1:0] ptr;

  // first requesting index at or above the pointer, wrapping
  always_comb begin
    int cand;
    winValid = 1'b0;
    winIdx   = '0;
    for (int off = 0; off < NUM_REQ; off++) begin
      cand = int'(ptr) + off;
      if (cand >= NUM_REQ) cand = cand - NUM_REQ;
      if (!winValid && reqVec[cand]) begin
        winValid = 1'b1;
        winIdx   = IDX_W'(cand);
      end
    end
  end

  // pointer moves only once the granted transfer has finished
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptr <= '0;
    end else if (advance) begin
      if (int'(advIdx) == NUM_REQ - 1) ptr <= '0;
      else                             ptr <= advIdx + IDX_W'(1);
    end
  end

  // R7: the pointer never rests outside the requester range
  p_ptr_in_range_r7: assert property (@(posedge clk) disable iff (!rstN)
    int'(ptr) < NUM_REQ);

endmodule

// File: rtl/swap_bus_ctrl.sv
module swap_bus_ctrl
  import swap_bus_pkg::*;
#(
  parameter int NUM_REQ = 4,
  localparam int IDX_W = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [NUM_REQ-1:0]      reqValid,
  input  logic [OP_W*NUM_REQ-1:0] reqOp,
  input  logic                    winValid,
  input  logic [IDX_W-1:0]        winIdx,
  output logic [NUM_REQ-1:0]      arbReq,
  output logic                    advance,
  output logic [IDX_W-1:0]        ownerIdx,
  output logic [NUM_REQ-1:0]      grant,
  output logic [NUM_REQ-1:0]      done,
  output dpStrobe_t               strobe
);

  typedef enum logic [1:0] {ST_IDLE, ST_ACCESS, ST_SWAPWR} busState_e;

  busState_e state;
  busOp_e    opQ;
  busOp_e    winOp;
  logic      isSwap;
  logic      isWrite;

  // a requester whose done is showing has finished; its valid is stale
  assign arbReq = reqValid & ~done;

  always_comb begin
    winOp = OP_READ;
    for (int i = 0; i < NUM_REQ; i++) begin
      if (IDX_W'(i) == winIdx) winOp = busOp_e'(reqOp[i*OP_W +: OP_W]);
    end
  end

  assign isSwap  = (opQ == OP_SWAP);
  assign isWrite = (opQ == OP_WRITE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      opQ      <= OP_READ;
      ownerIdx <= '0;
      grant    <= '0;
      done     <= '0;
    end else begin
      done <= '0;
      unique case (state)
        ST_IDLE: begin
          if (winValid) begin
            ownerIdx      <= winIdx;
            opQ           <= winOp;
            grant         <= '0;
            grant[winIdx] <= 1'b1;
            state         <= ST_ACCESS;
          end
        end
        ST_ACCESS: begin
          if (isSwap) begin
            state <= ST_SWAPWR;   // keep the bus for the write phase
          end else begin
            done  <= grant;
            grant <= '0;
            state <= ST_IDLE;
          end
        end
        ST_SWAPWR: begin
          done  <= grant;
          grant <= '0;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe          = '0;
    strobe.latchReq = (state == ST_IDLE) && winValid;
    strobe.capRead  = (state == ST_ACCESS) && !isWrite;
    strobe.clrRead  = (state == ST_ACCESS) && isWrite;
    strobe.memWrite = ((state == ST_ACCESS) && isWrite) || (state == ST_SWAPWR);
    advance         = ((state == ST_ACCESS) && !isSwap) || (state == ST_SWAPWR);
  end

  // R6: single bus owner
  p_grant_onehot_r6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grant));

  // R5: a swap keeps the same owner into its write phase
  p_swap_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ACCESS && isSwap) |=> (state == ST_SWAPWR && $stable(grant) && |grant));

  // R8: completion goes to the previous cycle's owner, one at a time
  p_done_follows_grant_r8: assert property (@(posedge clk) disable iff (!rstN)
    (|done) |-> (done == $past(grant)));

  p_done_onehot_r8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(done));

  // R7: ownership is only granted to a requester that was asking
  p_grant_from_req_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(|grant) |-> |($past(reqValid) & grant));

endmodule

// File: rtl/swap_bus_dp.sv
module swap_bus_dp
  import swap_bus_pkg::*;
#(
  parameter int NUM_REQ = 4,
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 16,
  localparam int IDX_W  = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1,
  localparam int DEPTH  = 1 << ADDR_W
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  dpStrobe_t                 strobe,
  input  logic [IDX_W-1:0]          selIdx,
  input  logic [ADDR_W*NUM_REQ-1:0] reqAddr,
  input  logic [DATA_W*NUM_REQ-1:0] reqWdata,
  output logic [DATA_W-1:0]         rdata
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;
  logic [DATA_W-1:0] rdataQ;
  logic [ADDR_W-1:0] selAddr;
  logic [DATA_W-1:0] selData;

  always_comb begin
    selAddr = '0;
    selData = '0;
    for (int i = 0; i < NUM_REQ; i++) begin
      if (IDX_W'(i) == selIdx) begin
        selAddr = reqAddr[i*ADDR_W +: ADDR_W];
        selData = reqWdata[i*DATA_W +: DATA_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
    end else if (strobe.latchReq) begin
      addrQ  <= selAddr;
      wdataQ <= selData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int w = 0; w < DEPTH; w++) mem[w] <= '0;
    end else if (strobe.memWrite) begin
      mem[addrQ] <= wdataQ;
    end
  end

  // response register holds the old word through a swap's write phase
  always_ff @(posedge clk) begin
    if (!rstN)               rdataQ <= '0;
    else if (strobe.clrRead) rdataQ <= '0;
    else if (strobe.capRead) rdataQ <= mem[addrQ];
  end

  assign rdata = rdataQ;

  // R4: a write phase leaves the held data in the held word
  p_write_lands_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.memWrite |=> (mem[$past(addrQ)] == $past(wdataQ)));

  // R6: the address cannot be replaced while a transfer is in flight
  p_addr_held_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.capRead && !strobe.memWrite) |=> $stable(addrQ));

endmodule

// File: rtl/swap_lock_bus.sv
module swap_lock_bus
  import swap_bus_pkg::*;
#(
  parameter int NUM_REQ = 4,
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 16
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NUM_REQ-1:0]        reqValid,
  input  logic [OP_W*NUM_REQ-1:0]   reqOp,
  input  logic [ADDR_W*NUM_REQ-1:0] reqAddr,
  input  logic [DATA_W*NUM_REQ-1:0] reqWdata,
  output logic [NUM_REQ-1:0]        grant,
  output logic [NUM_REQ-1:0]        done,
  output logic [DATA_W-1:0]         rdata
);

  localparam int IDX_W = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1;

  logic [NUM_REQ-1:0] arbReq;
  logic               winValid;
  logic [IDX_W-1:0]   winIdx;
  logic               advance;
  logic [IDX_W-1:0]   ownerIdx;
  dpStrobe_t          strobe;

  swap_rr_arbiter #(.NUM_REQ(NUM_REQ)) uArb (
    .clk      (clk),
    .rstN     (rstN),
    .reqVec   (arbReq),
    .advance  (advance),
    .advIdx   (ownerIdx),
    .winValid (winValid),
    .winIdx   (winIdx)
  );

  swap_bus_ctrl #(.NUM_REQ(NUM_REQ)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqOp    (reqOp),
    .winValid (winValid),
    .winIdx   (winIdx),
    .arbReq   (arbReq),
    .advance  (advance),
    .ownerIdx (ownerIdx),
    .grant    (grant),
    .done     (done),
    .strobe   (strobe)
  );

  swap_bus_dp #(.NUM_REQ(NUM_REQ), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .selIdx   (winIdx),
    .reqAddr  (reqAddr),
    .reqWdata (reqWdata),
    .rdata    (rdata)
  );

endmodule

// File: tb/tb_swap_lock_bus.sv
module tb_swap_lock_bus;

  localparam int N     = 4;
  localparam int AW    = 4;
  localparam int DW    = 16;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rstN;
  logic [N-1:0]  reqValid;
  logic [2*N-1:0]  reqOp;
  logic [AW*N-1:0] reqAddr;
  logic [DW*N-1:0] reqWdata;
  logic [N-1:0]  grant;
  logic [N-1:0]  done;
  logic [DW-1:0] rdata;

  always #10 clk = ~clk;   // 50 MHz

  swap_lock_bus #(.NUM_REQ(N), .ADDR_W(AW), .DATA_W(DW)) dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .grant(grant), .done(done), .rdata(rdata)
  );

  int checks   = 0;
  int failures = 0;
  bit finished = 0;
  logic [DW-1:0] model [DEPTH];
  int ptr = 0;
  logic [DW-1:0] got [N];

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int pickNext(logic [N-1:0] pend, int p);
    for (int off = 0; off < N; off++) begin
      int c = (p + off) % N;
      if (pend[c]) return c;
    end
    return -1;
  endfunction

  function automatic logic [DW-1:0] expectData(logic [1:0] op, logic [DW-1:0] old);
    if (op == 2'b01) return '0;
    return old;
  endfunction

  function automatic string opTag(logic [1:0] op);
    case (op)
      2'b00: return "R2";
      2'b01: return "R3";
      2'b10: return "R4";
      default: return "R10";
    endcase
  endfunction

  // present a set of simultaneous requests and follow them to completion
  task automatic runRound(logic [N-1:0] act, logic [1:0] ops [N],
                          logic [AW-1:0] addrs [N], logic [DW-1:0] datas [N]);
    logic [N-1:0] pend;
    int gcnt [N];
    int waitCyc;
    @(negedge clk);
    for (int i = 0; i < N; i++) begin
      reqOp[2*i +: 2]     = ops[i];
      reqAddr[AW*i +: AW] = addrs[i];
      reqWdata[DW*i +: DW] = datas[i];
      gcnt[i] = 0;
      got[i]  = 'x;
    end
    reqValid = act;
    pend     = act;
    waitCyc  = 0;
    while (pend != 0) begin
      @(negedge clk);
      waitCyc++;
      if ($countones(grant) > 1)
        check(0, "R6", "grant bits high", $countones(grant), 1);
      for (int i = 0; i < N; i++) if (grant[i]) gcnt[i]++;
      if (done != 0) begin
        int idx = -1;
        int expIdx;
        logic [DW-1:0] expData;
        check($countones(done) == 1 && (done & ~pend) == 0, "R8", "done vector", done, pend);
        for (int i = 0; i < N; i++) if (done[i]) idx = i;
        expIdx = pickNext(pend, ptr);
        check(idx == expIdx, "R7", "completing requester", idx, expIdx);
        if (idx >= 0) begin
          expData = expectData(ops[idx], model[addrs[idx]]);
          check(rdata == expData, opTag(ops[idx]), "rdata", rdata, expData);
          check(gcnt[idx] == ((ops[idx] == 2'b10) ? 2 : 1), "R5", "grant cycles",
                gcnt[idx], (ops[idx] == 2'b10) ? 2 : 1);
          got[idx] = rdata;
          if (ops[idx] == 2'b01 || ops[idx] == 2'b10) model[addrs[idx]] = datas[idx];
          ptr = (idx + 1) % N;
          pend[idx] = 1'b0;
          reqValid[idx] = 1'b0;
          gcnt[idx] = 0;
        end
      end
      if (waitCyc > 40) begin
        check(0, "R8", "requests left without done", pend, 0);
        reqValid = '0;
        pend = '0;
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [1:0]    ops   [N];
    logic [AW-1:0] addrs [N];
    logic [DW-1:0] datas [N];
    int zeros;
    void'($urandom(32'd1234));
    for (int w = 0; w < DEPTH; w++) model[w] = '0;
    rstN = 1'b0; reqValid = '0; reqOp = '0; reqAddr = '0; reqWdata = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(grant == '0, "R1", "grant after reset", grant, 0);
    check(done == '0, "R1", "done after reset", done, 0);

    // R1: contents read back as zero, all four requesters together
    for (int i = 0; i < N; i++) begin
      ops[i] = 2'b00; addrs[i] = AW'(i * 5); datas[i] = '1;
    end
    runRound('1, ops, addrs, datas);
    for (int i = 0; i < N; i++) check(got[i] == '0, "R1", "reset word", got[i], 0);

    // R3 then R2 and R10: write then read back with both read codes
    ops[0] = 2'b01; addrs[0] = 4'd9; datas[0] = 16'hBEEF;
    runRound(4'b0001, ops, addrs, datas);
    ops[2] = 2'b11; addrs[2] = 4'd9;
    ops[3] = 2'b00; addrs[3] = 4'd9;
    runRound(4'b1100, ops, addrs, datas);
    check(got[2] == 16'hBEEF, "R10", "alt read value", got[2], 16'hBEEF);

    // R4: swap returns the old word, a later read sees the new one
    ops[1] = 2'b10; addrs[1] = 4'd9; datas[1] = 16'h1234;
    runRound(4'b0010, ops, addrs, datas);
    check(got[1] == 16'hBEEF, "R4", "swap old value", got[1], 16'hBEEF);
    ops[0] = 2'b00; addrs[0] = 4'd9;
    runRound(4'b0001, ops, addrs, datas);
    check(got[0] == 16'h1234, "R4", "value after swap", got[0], 16'h1234);

    // R9: lock contest, all swap 1 into a free lock word
    ops[0] = 2'b01; addrs[0] = 4'd5; datas[0] = '0;
    runRound(4'b0001, ops, addrs, datas);
    for (int i = 0; i < N; i++) begin
      ops[i] = 2'b10; addrs[i] = 4'd5; datas[i] = 16'd1;
    end
    runRound('1, ops, addrs, datas);
    zeros = 0;
    for (int i = 0; i < N; i++) if (got[i] == '0) zeros++;
    check(zeros == 1, "R9", "lock winners", zeros, 1);

    // random mixes with colliding addresses
    for (int r = 0; r < 400; r++) begin
      logic [N-1:0] act;
      act = N'($urandom);
      if (act == '0) act = N'(1) << ($urandom % N);
      for (int i = 0; i < N; i++) begin
        ops[i]   = 2'($urandom);
        addrs[i] = AW'($urandom % 6);
        datas[i] = DW'($urandom);
      end
      runRound(act, ops, addrs, datas);
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule